// File: doc/BRIEF.md
# UART FIFO Control Logic

This block holds the two byte queues of a buffered UART and the control register that governs them. A transmit queue takes bytes from the CPU and hands them to the serializer. A receive queue takes bytes from the deserializer and hands them to the CPU. A single CPU write port sets four things: whether the queues are enabled, whether each queue is flushed, which of two ready-pin signalling modes is used, and the receive fill level that counts as "trigger reached".

The block reports both fill levels, overrun pulses for pushes that are dropped, a trigger-reached flag, and two active-low ready pins for a DMA engine. The control state is visible as one byte, `ctrl_state`. Its bit 0 is the enable, bit 3 is the ready-pin mode, and bits 7:6 are the trigger select. All other bits read 0. With the queues disabled, each queue holds a single byte, as a plain holding register would. With them enabled, each holds `DEPTH` bytes.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: A control write with bit 0 = 0 clears `ctrl_state[0]` and empties both queues, so both counts read 0 on the cycle after the write.
- R2: A control write with bit 0 = 1 while `ctrl_state[0]` = 0 sets the enable and empties both queues. A write with bit 0 = 1 while already enabled, and with bits 2:1 = 0, leaves both queue contents and counts intact.
- R3: When a control write has bit 0 = 0, its bits 7:1 are discarded and `ctrl_state[7:1]` keeps its previous value.
- R4: A control write with bits 1 and 0 both set empties only the receive queue. `ctrl_state[1]` always reads 0.
- R5: A control write with bits 2 and 0 both set empties only the transmit queue. `ctrl_state[2]` always reads 0.
- R6: Bits 7:6 of an enabling write select the receive trigger level: 00 selects 1 byte, 01 selects 4, 10 selects 8 and 11 selects 14. `rx_trig_hit` is 1 exactly while `rx_count` is at or above the selected level.
- R7: Bits 5:4 of a control write have no effect. `ctrl_state[5:4]` reads 0, and the other fields and the counts are those the write would give without them.
- R8: Each queue returns bytes in push order. It holds `DEPTH` bytes when enabled and 1 byte when disabled. A push into a full queue with no pop in the same cycle is dropped, the count is unchanged, and the matching overrun output is 1 during that cycle.
- R9: A pop updates the read-data output on the following cycle. A pop on an empty queue leaves the read data and the count unchanged and raises no overrun.
- R10: In mode 0 (`ctrl_state[0]` = 0 or `ctrl_state[3]` = 0), `rxrdy_n` is 0 exactly when `rx_count` > 0, and `txrdy_n` is 0 exactly when `tx_count` = 0.
- R11: In mode 1 (`ctrl_state[0]` = 1 and `ctrl_state[3]` = 1), `rxrdy_n` is 0 when `rx_trig_hit` is 1, or when `rx_timeout` is 1 and the receive queue is not empty.
- R12: In mode 1, `txrdy_n` goes to 0 when the transmit queue is empty. It stays 0 while the queue refills, goes to 1 when the queue is full, and stays 1 until the queue is empty again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| ctrl_state | output | 8 | Current control state: bit 0 enable, bit 3 mode, bits 7:6 trigger select, other bits 0 |
| tx_push | input | 1 | CPU pushes a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Serializer takes a byte from the transmit queue |
| tx_rdata | output | 8 | Last byte taken from the transmit queue |
| tx_count | output | CW | Transmit queue fill level |
| tx_overrun | output | 1 | Transmit push dropped in this cycle |
| rx_push | input | 1 | Deserializer pushes a byte into the receive queue |
| rx_wdata | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | CPU takes a byte from the receive queue |
| rx_rdata | output | 8 | Last byte taken from the receive queue |
| rx_count | output | CW | Receive queue fill level |
| rx_overrun | output | 1 | Receive push dropped in this cycle |
| rx_timeout | input | 1 | Character timeout from the receiver |
| rx_trig_hit | output | 1 | Receive level at or above the trigger |
| rxrdy_n | output | 1 | Active-low receive ready pin |
| txrdy_n | output | 1 | Active-low transmit ready pin |

## Verification
The bound checker watches, on every cycle, the flushing effects of each control write (R1, R2, R4, R5) and that discarded fields are held (R3). It also watches the trigger comparison against an independently written level table (R6), count bounds and dropped pushes (R8), the stable read data on empty pops (R9), and the ready-pin equations in both modes (R10, R11, R12). Only the bench's scenarios can show byte ordering through a full queue, the one-byte capacity while disabled, that contents survive a non-flushing rewrite, and the hysteresis of the mode 1 transmit pin across a complete fill and drain.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic [1:0] trig;
    logic       dma;
    logic       en;
  } fifo_cfg_t;

  // Receive trigger threshold in bytes for a two-bit select
  function automatic int unsigned rx_trig_bytes(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // Control state byte as seen by software
  function automatic logic [7:0] pack_state(input fifo_cfg_t c);
    return {c.trig, 2'b00, c.dma, 2'b00, c.en};
  endfunction

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          overrun
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          empty, do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = single ? !empty : (count == FULL_CNT);
  assign do_pop  = pop && !empty && !flush;
  assign do_push = push && !flush && (!full || do_pop);
  assign overrun = push && !flush && !do_push;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      rdata  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop) begin
        rd_ptr <= next_ptr(rd_ptr);
        rdata  <= mem[rd_ptr];
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/uart_fifo_cfg.sv
module uart_fifo_cfg
  import uart_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output fifo_cfg_t  cfg,
  output logic       rx_flush,
  output logic       tx_flush
);

  logic en_edge;
  logic unused_rsvd;

  // Reserved field bits are accepted and dropped
  assign unused_rsvd = ^wdata[5:4];

  // Off-to-on transition, or any disabling write, empties both queues
  assign en_edge  = we && (!wdata[0] || !cfg.en);
  assign rx_flush = en_edge || (we && wdata[0] && wdata[1]);
  assign tx_flush = en_edge || (we && wdata[0] && wdata[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (we) begin
      if (wdata[0]) begin
        cfg.en   <= 1'b1;
        cfg.dma  <= wdata[3];
        cfg.trig <= wdata[7:6];
      end else begin
        cfg.en <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_rdy_gen.sv
module uart_rdy_gen
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode1,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] rx_count,
  input  logic          rx_timeout,
  input  logic [CW-1:0] tx_count,
  input  logic          tx_full,
  output logic          rx_trig_hit,
  output logic          rxrdy_n,
  output logic          txrdy_n
);

  logic tx_arm;
  logic rx_any, tx_empty;

  assign rx_any      = (rx_count != '0);
  assign tx_empty    = (tx_count == '0);
  assign rx_trig_hit = (rx_count >= CW'(rx_trig_bytes(trig_sel)));

  // Transmit ready hysteresis: armed by empty, disarmed by full
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tx_arm <= 1'b1;
    else if (tx_empty) tx_arm <= 1'b1;
    else if (tx_full)  tx_arm <= 1'b0;
  end

  always_comb begin
    if (mode1) begin
      rxrdy_n = !(rx_trig_hit || (rx_timeout && rx_any));
      txrdy_n = !((tx_empty || tx_arm) && !tx_full);
    end else begin
      rxrdy_n = !rx_any;
      txrdy_n = !tx_empty;
    end
  end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        ctrl_state,
  input  logic              tx_push,
  input  logic [BYTE_W-1:0] tx_wdata,
  input  logic              tx_pop,
  output logic [BYTE_W-1:0] tx_rdata,
  output logic [CW-1:0]     tx_count,
  output logic              tx_overrun,
  input  logic              rx_push,
  input  logic [BYTE_W-1:0] rx_wdata,
  input  logic              rx_pop,
  output logic [BYTE_W-1:0] rx_rdata,
  output logic [CW-1:0]     rx_count,
  output logic              rx_overrun,
  input  logic              rx_timeout,
  output logic              rx_trig_hit,
  output logic              rxrdy_n,
  output logic              txrdy_n
);

  fifo_cfg_t cfg;
  logic      rx_flush, tx_flush;
  logic      rx_full, tx_full;
  logic      mode1, single;

  assign mode1      = cfg.en && cfg.dma;
  assign single     = !cfg.en;
  assign ctrl_state = pack_state(cfg);

  uart_fifo_cfg i_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .wdata    (cfg_wdata),
    .cfg      (cfg),
    .rx_flush (rx_flush),
    .tx_flush (tx_flush)
  );

  uart_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) i_tx_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (tx_flush),
    .single  (single),
    .push    (tx_push),
    .wdata   (tx_wdata),
    .pop     (tx_pop),
    .rdata   (tx_rdata),
    .count   (tx_count),
    .full    (tx_full),
    .overrun (tx_overrun)
  );

  uart_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) i_rx_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (rx_flush),
    .single  (single),
    .push    (rx_push),
    .wdata   (rx_wdata),
    .pop     (rx_pop),
    .rdata   (rx_rdata),
    .count   (rx_count),
    .full    (rx_full),
    .overrun (rx_overrun)
  );

  uart_rdy_gen #(.DEPTH(DEPTH)) i_rdy (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode1       (mode1),
    .trig_sel    (cfg.trig),
    .rx_count    (rx_count),
    .rx_timeout  (rx_timeout),
    .tx_count    (tx_count),
    .tx_full     (tx_full),
    .rx_trig_hit (rx_trig_hit),
    .rxrdy_n     (rxrdy_n),
    .txrdy_n     (txrdy_n)
  );

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [7:0]    cfg_wdata,
  input logic [7:0]    ctrl_state,
  input logic          rx_push,
  input logic          rx_pop,
  input logic [7:0]    rx_rdata,
  input logic [CW-1:0] rx_count,
  input logic          rx_overrun,
  input logic          rx_timeout,
  input logic          rx_trig_hit,
  input logic [CW-1:0] tx_count,
  input logic          tx_overrun,
  input logic          rxrdy_n,
  input logic          txrdy_n
);

  logic [CW-1:0] lvl;
  logic          m1;

  always_comb begin
    unique case (ctrl_state[7:6])
      2'b11:   lvl = CW'(14);
      2'b10:   lvl = CW'(8);
      2'b01:   lvl = CW'(4);
      default: lvl = CW'(1);
    endcase
  end
  assign m1 = ctrl_state[0] && ctrl_state[3];

  a_r1_disable_flush: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_wdata[0] |=> (rx_count == '0) && (tx_count == '0) && !ctrl_state[0]);

  a_r2_enable_flush: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[0] && !ctrl_state[0] |=> (rx_count == '0) && (tx_count == '0) && ctrl_state[0]);

  a_r3_gated_fields: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_wdata[0] |=> ctrl_state[7:1] == $past(ctrl_state[7:1]));

  a_r4_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[0] && cfg_wdata[1] |=> (rx_count == '0) && !ctrl_state[1]);

  a_r5_tx_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_wdata[0] && cfg_wdata[2] |=> (tx_count == '0) && !ctrl_state[2]);

  a_r6_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    rx_trig_hit == (rx_count >= lvl));

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ctrl_state[5:4] == 2'b00);

  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_count <= CW'(DEPTH)) && (tx_count <= CW'(DEPTH)));

  a_r8_rx_drop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun && !cfg_we |=> rx_count == $past(rx_count));

  a_r9_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop && (rx_count == '0) |=> $stable(rx_rdata));

  a_r9_empty_no_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_push |-> !rx_overrun);

  a_r10_mode0_pins: assert property (@(posedge clk) disable iff (!rst_n)
    !m1 |-> (rxrdy_n == (rx_count == '0)) && (txrdy_n == (tx_count != '0)));

  a_r11_rx_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    m1 && rx_timeout && (rx_count != '0) |-> !rxrdy_n);

  a_r12_tx_full: assert property (@(posedge clk) disable iff (!rst_n)
    m1 && (tx_count == CW'(DEPTH)) |-> txrdy_n);

  a_r12_tx_empty: assert property (@(posedge clk) disable iff (!rst_n)
    m1 && (tx_count == '0) |-> !txrdy_n);

  a_r11_tx_overrun_free: assert property (@(posedge clk) disable iff (!rst_n)
    tx_overrun |-> tx_count != '0);

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_wdata   (cfg_wdata),
  .ctrl_state  (ctrl_state),
  .rx_push     (rx_push),
  .rx_pop      (rx_pop),
  .rx_rdata    (rx_rdata),
  .rx_count    (rx_count),
  .rx_overrun  (rx_overrun),
  .rx_timeout  (rx_timeout),
  .rx_trig_hit (rx_trig_hit),
  .tx_count    (tx_count),
  .tx_overrun  (tx_overrun),
  .rxrdy_n     (rxrdy_n),
  .txrdy_n     (txrdy_n)
);

// File: tb/test_uart_fifo_ctrl.sv
`timescale 1ns/1ps
module test_uart_fifo_ctrl;

  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [7:0]    cfg_wdata = '0;
  logic [7:0]    ctrl_state;
  logic          tx_push = 1'b0, tx_pop = 1'b0;
  logic [7:0]    tx_wdata = '0, tx_rdata;
  logic [CW-1:0] tx_count;
  logic          tx_overrun;
  logic          rx_push = 1'b0, rx_pop = 1'b0;
  logic [7:0]    rx_wdata = '0, rx_rdata;
  logic [CW-1:0] rx_count;
  logic          rx_overrun;
  logic          rx_timeout = 1'b0;
  logic          rx_trig_hit, rxrdy_n, txrdy_n;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  bit  en_m = 0;
  logic [7:0] rx_q[$], tx_q[$];
  bit  rx_pend = 0, tx_pend = 0;

  always #2.5 clk = ~clk;

  uart_fifo_ctrl #(.DEPTH(DEPTH)) i_uart_fifo_ctrl (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: a pop that the scoreboard says is non-empty yields data next cycle
  always @(posedge clk) begin
    rx_pend <= rx_pop && (rx_q.size() != 0);
    tx_pend <= tx_pop && (tx_q.size() != 0);
  end
  always @(negedge clk) begin
    if (rx_pend) chk("R8 rx order", rx_rdata, rx_q.pop_front());
    if (tx_pend) chk("R8 tx order", tx_rdata, tx_q.pop_front());
  end

  task automatic cfg_write(input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = d;
    if (!d[0] || !en_m || d[1]) rx_q.delete();
    if (!d[0] || !en_m || d[2]) tx_q.delete();
    en_m = d[0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] d, input bit exp_ovr);
    @(negedge clk);
    rx_push = 1'b1; rx_wdata = d;
    #0.5 chk("R8 rx overrun", rx_overrun, exp_ovr);
    if (!exp_ovr) rx_q.push_back(d);
    @(negedge clk);
    rx_push = 1'b0;
    chk("R8 rx count", rx_count, rx_q.size());
  endtask

  task automatic tx_put(input logic [7:0] d, input bit exp_ovr);
    @(negedge clk);
    tx_push = 1'b1; tx_wdata = d;
    #0.5 chk("R8 tx overrun", tx_overrun, exp_ovr);
    if (!exp_ovr) tx_q.push_back(d);
    @(negedge clk);
    tx_push = 1'b0;
    chk("R8 tx count", tx_count, tx_q.size());
  endtask

  task automatic rx_get();
    @(negedge clk); rx_pop = 1'b1;
    @(negedge clk); rx_pop = 1'b0;
  endtask

  task automatic tx_get();
    @(negedge clk); tx_pop = 1'b1;
    @(negedge clk); tx_pop = 1'b0;
  endtask

  function automatic int lvl_of(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 4 : (s == 2'd2) ? 8 : 14;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk("R1 reset state", ctrl_state, 0);
    chk("R8 reset rx count", rx_count, 0);
    chk("R10 reset rxrdy_n", rxrdy_n, 1);
    chk("R10 reset txrdy_n", txrdy_n, 0);

    // Disabled: one-byte capacity (R8)
    rx_put(8'h11, 0);
    rx_put(8'h22, 1);
    chk("R10 rxrdy_n with data", rxrdy_n, 0);
    rx_get();
    @(negedge clk);

    // Enable and program trigger 14 (R2, R6)
    cfg_write(8'hC1);
    chk("R2 enabled state", ctrl_state, 8'hC1);
    for (int i = 0; i < 13; i++) rx_put(8'h40 + 8'(i), 0);
    chk("R6 below 14", rx_trig_hit, 0);
    rx_put(8'h4D, 0);
    chk("R6 at 14", rx_trig_hit, 1);
    rx_put(8'h4E, 0);
    rx_put(8'h4F, 0);
    rx_put(8'hEE, 1);
    cfg_write(8'hC1);
    chk("R2 no flush when enabled", rx_count, 16);
    for (int i = 0; i < 16; i++) rx_get();
    @(negedge clk);
    keep = rx_rdata;
    rx_get();
    @(negedge clk);
    chk("R9 empty pop data", rx_rdata, keep);
    chk("R9 empty pop count", rx_count, 0);

    // Trigger 4 (R6)
    cfg_write(8'h41);
    for (int i = 0; i < 3; i++) rx_put(8'h60 + 8'(i), 0);
    chk("R6 below 4", rx_trig_hit, 0);
    rx_put(8'h63, 0);
    chk("R6 at 4", rx_trig_hit, (4 >= lvl_of(2'b01)) ? 1 : 0);

    // Receive-only clear (R4)
    tx_put(8'hA1, 0);
    tx_put(8'hA2, 0);
    chk("R10 txrdy_n with data", txrdy_n, 1);
    cfg_write(8'h83);
    chk("R4 rx emptied", rx_count, 0);
    chk("R4 tx kept", tx_count, 2);
    chk("R4 readback", ctrl_state, 8'h81);

    // Transmit-only clear (R5)
    rx_put(8'h71, 0);
    cfg_write(8'h85);
    chk("R5 tx emptied", tx_count, 0);
    chk("R5 rx kept", rx_count, 1);
    chk("R5 readback", ctrl_state, 8'h81);

    // Reserved bits (R7)
    cfg_write(8'hB1);
    chk("R7 state", ctrl_state, 8'h81);
    chk("R7 rx kept", rx_count, 1);

    // Disabling write with other bits set (R1, R3)
    cfg_write(8'h4E);
    chk("R3 fields held", ctrl_state, 8'h80);
    chk("R1 rx emptied", rx_count, 0);

    // Mode 1, trigger 1 (R2)
    cfg_write(8'h09);
    chk("R2 mode1 state", ctrl_state, 8'h09);

    // Mode 1 transmit hysteresis (R12)
    chk("R12 empty active", txrdy_n, 0);
    for (int i = 0; i < 15; i++) tx_put(8'h80 + 8'(i), 0);
    chk("R12 filling active", txrdy_n, 0);
    tx_put(8'h8F, 0);
    chk("R12 full inactive", txrdy_n, 1);
    @(negedge clk);
    tx_get();
    chk("R12 draining inactive", txrdy_n, 1);
    for (int i = 0; i < 15; i++) tx_get();
    @(negedge clk);
    chk("R12 empty again", txrdy_n, 0);

    // Mode 1 receive with trigger 8 (R11)
    cfg_write(8'h89);
    rx_put(8'h91, 0);
    chk("R11 below trigger", rxrdy_n, 1);
    @(negedge clk); rx_timeout = 1'b1;
    #0.5 chk("R11 timeout", rxrdy_n, 0);
    @(negedge clk); rx_timeout = 1'b0;
    for (int i = 0; i < 7; i++) rx_put(8'hB0 + 8'(i), 0);
    chk("R11 at trigger", rxrdy_n, 0);
    chk("R6 at 8", rx_trig_hit, 1);
    for (int i = 0; i < 8; i++) rx_get();
    @(negedge clk);
    chk("R11 empty", rxrdy_n, 1);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule